// File: doc/BRIEF.md
# Prewitt gradient magnitude unit

This block turns one 3x3 grayscale neighbourhood into an edge-strength pixel for the centre of that neighbourhood. An upstream window extractor presents the eight surrounding pixels on every cycle it has a window ready. The unit forms two Prewitt gradients from them. One is the top row minus the bottom row. The other is the right column minus the left column. The unit then adds their absolute values and clamps the total to the pixel range. The centre pixel plays no part in the result, so it has no port.

The datapath is pipelined with a fixed latency of two clock cycles. The first register stage holds the two absolute gradients, and the second holds the clamped result. A valid flag travels with the data. Data registers load only when their stage carries a valid window, so the output pixel keeps its last value between windows. Line buffering, window extraction, thresholding, direction and frame handling all sit outside the block.

Top module: `prewitt_mag`

## Requirements
- R1: The horizontal-edge gradient is the sum of the top row (nb_tl, nb_tc, nb_tr) minus the sum of the bottom row (nb_bl, nb_bc, nb_br). For example, a top row of v with every other pixel 0 yields out_pix = min(3v, 255).
- R2: The vertical-edge gradient is the sum of the right column (nb_tr, nb_mr, nb_br) minus the sum of the left column (nb_tl, nb_ml, nb_bl). For example, a right column of v with every other pixel 0 yields out_pix = min(3v, 255).
- R3: out_pix equals |Gx| + |Gy| when that total is at most 2^PIX_W-1, and equals 2^PIX_W-1 otherwise. The window 12,167,120 / 50,_,23 / 1,123,25 gives Gx=150, Gy=105 and out_pix=255.
- R4: out_valid is high exactly two rising clock edges after a cycle in which in_valid is high, and the out_pix of that cycle belongs to that window.
- R5: While no valid window reaches the output, out_valid is 0 and out_pix keeps the value of the last valid result, whatever the pixel inputs carry.
- R6: While rst_n is low, out_valid and out_pix are 0, and windows accepted before the reset never appear at the output.
- R7: Gradients at the extremes of ±3(2^PIX_W-1) have the correct magnitude, and negative gradients give the same magnitude as the mirrored positive ones.
- R8: A window whose eight pixels are all equal yields out_pix = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | The eight neighbour pixels carry a window this cycle |
| nb_tl | input | PIX_W | Top-left neighbour |
| nb_tc | input | PIX_W | Top-centre neighbour |
| nb_tr | input | PIX_W | Top-right neighbour |
| nb_ml | input | PIX_W | Middle-left neighbour |
| nb_mr | input | PIX_W | Middle-right neighbour |
| nb_bl | input | PIX_W | Bottom-left neighbour |
| nb_bc | input | PIX_W | Bottom-centre neighbour |
| nb_br | input | PIX_W | Bottom-right neighbour |
| out_valid | output | 1 | out_pix carries a new result |
| out_pix | output | PIX_W | Clamped gradient magnitude for the window centre |

## Verification
The bench builds the unit at its default pixel width of 8 bits. At that width it can sweep every value from 0 to 255 through each of the eight neighbour positions on its own, which covers both signs of each gradient and the clamp threshold. It also streams directed row, column, uniform and extreme windows back to back, and then thousands of pseudo-random windows. Some of the random windows have low contrast, so that many unclamped sums are compared exactly. Idle gaps are filled with junk pixels, and one reset is applied in the middle of the stream. Together these check that results hold between windows and that windows flushed by the reset never surface.

// File: rtl/prewitt_pkg.sv
package prewitt_pkg;

  // Width of an unsigned three-pixel sum.
  function automatic int unsigned tri_sum_w(input int unsigned pix_w);
    return pix_w + 2;
  endfunction

  // Width of a signed gradient (three-pixel sum difference).
  function automatic int unsigned grad_w(input int unsigned pix_w);
    return pix_w + 3;
  endfunction

  // Number of gradient axes handled in parallel.
  localparam int unsigned NUM_AXES = 2;
  localparam int unsigned TAPS_PER_SIDE = 3;

endpackage

// File: rtl/prewitt_grad.sv
module prewitt_grad
  import prewitt_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  localparam int unsigned SUM_W = tri_sum_w(PIX_W),
  localparam int unsigned GRD_W = grad_w(PIX_W)
) (
  input  logic [PIX_W-1:0]        pos_a,
  input  logic [PIX_W-1:0]        pos_b,
  input  logic [PIX_W-1:0]        pos_c,
  input  logic [PIX_W-1:0]        neg_a,
  input  logic [PIX_W-1:0]        neg_b,
  input  logic [PIX_W-1:0]        neg_c,
  output logic signed [GRD_W-1:0] grad
);

  logic [SUM_W-1:0] pos_sum;
  logic [SUM_W-1:0] neg_sum;

  always_comb begin
    pos_sum = {2'b00, pos_a} + {2'b00, pos_b} + {2'b00, pos_c};
    neg_sum = {2'b00, neg_a} + {2'b00, neg_b} + {2'b00, neg_c};
    grad    = $signed({1'b0, pos_sum}) - $signed({1'b0, neg_sum});
  end

endmodule

// File: rtl/prewitt_absval.sv
module prewitt_absval #(
  parameter int unsigned IN_W = 11,
  localparam int unsigned MAG_W = IN_W - 1
) (
  input  logic signed [IN_W-1:0] val,
  output logic [MAG_W-1:0]       mag
);

  logic [IN_W-1:0] raw;
  logic [IN_W-1:0] negated;

  always_comb begin
    raw     = val;
    negated = (~raw) + {{(IN_W-1){1'b0}}, 1'b1};
    mag     = raw[IN_W-1] ? negated[MAG_W-1:0] : raw[MAG_W-1:0];
  end

endmodule

// File: rtl/prewitt_satsum.sv
module prewitt_satsum #(
  parameter int unsigned MAG_W = 10,
  parameter int unsigned PIX_W = 8
) (
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  output logic [PIX_W-1:0] pix
);

  localparam logic [MAG_W:0] LIMIT = (MAG_W+1)'((1 << PIX_W) - 1);

  logic [MAG_W:0] total;

  always_comb begin
    total = {1'b0, mag_a} + {1'b0, mag_b};
    if (total > LIMIT) pix = '1;
    else               pix = total[PIX_W-1:0];
  end

endmodule

// File: rtl/prewitt_mag.sv
module prewitt_mag
  import prewitt_pkg::*;
#(
  parameter int unsigned PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] nb_tl,
  input  logic [PIX_W-1:0] nb_tc,
  input  logic [PIX_W-1:0] nb_tr,
  input  logic [PIX_W-1:0] nb_ml,
  input  logic [PIX_W-1:0] nb_mr,
  input  logic [PIX_W-1:0] nb_bl,
  input  logic [PIX_W-1:0] nb_bc,
  input  logic [PIX_W-1:0] nb_br,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix
);

  localparam int unsigned GRD_W   = grad_w(PIX_W);
  localparam int unsigned MAG_W   = GRD_W - 1;
  localparam logic [MAG_W-1:0] MAX_MAG = MAG_W'(3 * ((1 << PIX_W) - 1));
  localparam logic [MAG_W-1:0] PIX_MAX = MAG_W'((1 << PIX_W) - 1);

  // Tap routing: axis 0 = top row minus bottom row,
  //              axis 1 = right column minus left column.
  logic [PIX_W-1:0] pos_tap [NUM_AXES][TAPS_PER_SIDE];
  logic [PIX_W-1:0] neg_tap [NUM_AXES][TAPS_PER_SIDE];

  always_comb begin
    pos_tap[0][0] = nb_tl; pos_tap[0][1] = nb_tc; pos_tap[0][2] = nb_tr;
    neg_tap[0][0] = nb_bl; neg_tap[0][1] = nb_bc; neg_tap[0][2] = nb_br;
    pos_tap[1][0] = nb_tr; pos_tap[1][1] = nb_mr; pos_tap[1][2] = nb_br;
    neg_tap[1][0] = nb_tl; neg_tap[1][1] = nb_ml; neg_tap[1][2] = nb_bl;
  end

  logic signed [GRD_W-1:0] grad_c [NUM_AXES];
  logic [MAG_W-1:0]        mag_c  [NUM_AXES];
  logic [MAG_W-1:0]        mag_d  [NUM_AXES];
  logic [MAG_W-1:0]        mag_q  [NUM_AXES];

  for (genvar k = 0; k < NUM_AXES; k++) begin : g_axis
    prewitt_grad #(.PIX_W(PIX_W)) u_grad (
      .pos_a (pos_tap[k][0]),
      .pos_b (pos_tap[k][1]),
      .pos_c (pos_tap[k][2]),
      .neg_a (neg_tap[k][0]),
      .neg_b (neg_tap[k][1]),
      .neg_c (neg_tap[k][2]),
      .grad  (grad_c[k])
    );

    prewitt_absval #(.IN_W(GRD_W)) u_abs (
      .val (grad_c[k]),
      .mag (mag_c[k])
    );

    // Stage 1 next state: load on a valid window, hold otherwise.
    always_comb begin
      mag_d[k] = in_valid ? mag_c[k] : mag_q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mag_q[k] <= '0;
      else        mag_q[k] <= mag_d[k];
    end
  end

  logic             vld1_q;
  logic [PIX_W-1:0] sat_c;
  logic [PIX_W-1:0] pix_d;
  logic [PIX_W-1:0] pix_q;
  logic             vld2_q;

  prewitt_satsum #(.MAG_W(MAG_W), .PIX_W(PIX_W)) u_sat (
    .mag_a (mag_q[0]),
    .mag_b (mag_q[1]),
    .pix   (sat_c)
  );

  // Stage 2 next state: load the clamped sum only behind a valid window.
  always_comb begin
    pix_d = vld1_q ? sat_c : pix_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld1_q <= 1'b0;
      vld2_q <= 1'b0;
      pix_q  <= '0;
    end else begin
      vld1_q <= in_valid;
      vld2_q <= vld1_q;
      pix_q  <= pix_d;
    end
  end

  assign out_valid = vld2_q;
  assign out_pix   = pix_q;

  // Window accepted now reaches the output two edges later (R4).
  p_valid_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  // No output strobe without an input window two edges earlier (R4).
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

  // Output pixel holds when no window is in the last stage (R5).
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !vld1_q |=> $stable(out_pix));

  // A gradient magnitude never exceeds three full-scale pixels (R7).
  p_mag_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (mag_q[0] <= MAX_MAG) && (mag_q[1] <= MAX_MAG));

  // Uniform neighbourhood produces zero gradients (R8).
  p_flat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nb_tl == nb_tc && nb_tc == nb_tr && nb_tr == nb_ml &&
     nb_ml == nb_mr && nb_mr == nb_bl && nb_bl == nb_bc && nb_bc == nb_br)
    |=> (mag_q[0] == '0) && (mag_q[1] == '0));

  // A single gradient above full scale forces a clamped output (R3).
  p_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld1_q && (mag_q[0] > PIX_MAX || mag_q[1] > PIX_MAX)) |=> (out_pix == '1));

endmodule

// File: tb/prewitt_mag_test.sv
module prewitt_mag_test;

  localparam int PIX_W = 8;
  localparam int PMAX  = (1 << PIX_W) - 1;

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic [PIX_W-1:0] nb_tl, nb_tc, nb_tr, nb_ml, nb_mr, nb_bl, nb_bc, nb_br;
  logic             out_valid;
  logic [PIX_W-1:0] out_pix;

  int checks;
  int fails;
  bit done;

  // Expected-value pipeline mirroring the two-cycle latency.
  bit    e1v, e2v;
  int    e1d, e2d;
  string e1t, e2t;
  int    last_pix;
  int unsigned seed;

  prewitt_mag #(.PIX_W(PIX_W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .nb_tl     (nb_tl),
    .nb_tc     (nb_tc),
    .nb_tr     (nb_tr),
    .nb_ml     (nb_ml),
    .nb_mr     (nb_mr),
    .nb_bl     (nb_bl),
    .nb_bc     (nb_bc),
    .nb_br     (nb_br),
    .out_valid (out_valid),
    .out_pix   (out_pix)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int model(int tl, int tc, int tr, int ml, int mr,
                               int bl, int bc, int br);
    int gx, gy, g;
    gx = (tl + tc + tr) - (bl + bc + br);
    gy = (tr + mr + br) - (tl + ml + bl);
    g  = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
    return (g > PMAX) ? PMAX : g;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int unsigned rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  // One cycle: check what the pipeline owes, then present a new window.
  task automatic step(input int tl, input int tc, input int tr, input int ml,
                      input int mr, input int bl, input int bc, input int br,
                      input bit vld, input string tag);
    @(negedge clk);
    check(e2v ? {e2t, "/R4 valid"} : "R4 idle valid", int'(out_valid), int'(e2v));
    if (e2v) begin
      check(e2t, int'(out_pix), e2d);
      last_pix = e2d;
    end else begin
      check("R5 hold", int'(out_pix), last_pix);
    end
    e2v = e1v; e2d = e1d; e2t = e1t;
    e1v = vld;
    e1d = model(tl, tc, tr, ml, mr, bl, bc, br);
    e1t = tag;
    in_valid = vld;
    nb_tl = PIX_W'(tl); nb_tc = PIX_W'(tc); nb_tr = PIX_W'(tr);
    nb_ml = PIX_W'(ml); nb_mr = PIX_W'(mr);
    nb_bl = PIX_W'(bl); nb_bc = PIX_W'(bc); nb_br = PIX_W'(br);
  endtask

  task automatic junk_idle(input int n);
    for (int i = 0; i < n; i++) begin
      int unsigned r;
      r = rnd();
      step(int'(r & 8'hFF), int'((r >> 8) & 8'hFF), int'((r >> 16) & 8'hFF),
           int'(r >> 24), 255, 0, 17, 200, 1'b0, "R5");
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    #1;
    check("R6 reset valid", int'(out_valid), 0);
    check("R6 reset pix", int'(out_pix), 0);
    @(negedge clk);
    check("R6 reset held valid", int'(out_valid), 0);
    check("R6 reset held pix", int'(out_pix), 0);
    rst_n = 1'b1;
    e1v = 0; e2v = 0; last_pix = 0;
  endtask

  initial begin
    checks = 0; fails = 0; done = 0; seed = 32'h1234_5678;
    e1v = 0; e2v = 0; e1d = 0; e2d = 0; e1t = ""; e2t = ""; last_pix = 0;
    rst_n = 1'b0; in_valid = 1'b0;
    nb_tl = '0; nb_tc = '0; nb_tr = '0; nb_ml = '0;
    nb_mr = '0; nb_bl = '0; nb_bc = '0; nb_br = '0;
    #1;
    check("R6 initial valid", int'(out_valid), 0);
    check("R6 initial pix", int'(out_pix), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R3 worked example.
    step(12, 167, 120, 50, 23, 1, 123, 25, 1'b1, "R3 example");
    // R1 top row only, unclamped and clamped.
    step(40, 40, 40, 0, 0, 0, 0, 0, 1'b1, "R1 top row 40");
    step(85, 85, 85, 0, 0, 0, 0, 0, 1'b1, "R1 top row 85");
    step(0, 0, 0, 0, 0, 20, 20, 20, 1'b1, "R1 bottom row 20");
    // R2 right / left column.
    step(0, 0, 30, 0, 30, 0, 0, 30, 1'b1, "R2 right col 30");
    step(25, 0, 0, 25, 0, 25, 0, 0, 1'b1, "R2 left col 25");
    // R7 extremes and sign mirror.
    step(255, 255, 255, 0, 0, 0, 0, 0, 1'b1, "R7 top full");
    step(0, 0, 0, 0, 0, 255, 255, 255, 1'b1, "R7 bottom full");
    step(0, 0, 255, 0, 255, 0, 0, 255, 1'b1, "R7 right full");
    step(0, 0, 0, 0, 0, 10, 10, 10, 1'b1, "R7 negative 30");
    step(10, 10, 10, 0, 0, 0, 0, 0, 1'b1, "R7 positive 30");
    // R8 uniform windows.
    step(0, 0, 0, 0, 0, 0, 0, 0, 1'b1, "R8 flat 0");
    step(200, 200, 200, 200, 200, 200, 200, 200, 1'b1, "R8 flat 200");
    step(255, 255, 255, 255, 255, 255, 255, 255, 1'b1, "R8 flat 255");

    // R5 idle gap with junk pixels.
    step(50, 0, 0, 0, 0, 0, 0, 0, 1'b1, "R3 corner 50");
    junk_idle(6);

    // R3 sweep: every value at every neighbour position.
    for (int pos = 0; pos < 8; pos++) begin
      for (int v = 0; v <= PMAX; v++) begin
        int w [8];
        for (int j = 0; j < 8; j++) w[j] = 0;
        w[pos] = v;
        step(w[0], w[1], w[2], w[3], w[4], w[5], w[6], w[7], 1'b1, "R3 sweep");
      end
    end

    // R6 mid-stream reset flushes accepted windows.
    step(255, 255, 255, 0, 0, 0, 0, 0, 1'b1, "R6 pre-reset");
    step(90, 90, 90, 0, 0, 0, 0, 0, 1'b1, "R6 pre-reset");
    apply_reset();
    junk_idle(3);

    // R3 random windows, alternating full and low contrast, with gaps.
    for (int i = 0; i < 3000; i++) begin
      int unsigned a, b;
      int m;
      a = rnd(); b = rnd();
      m = (i % 2 == 0) ? 255 : 15;
      step(int'(a & 8'hFF) & m, int'((a >> 8) & 8'hFF) & m,
           int'((a >> 16) & 8'hFF) & m, int'(a >> 24) & m,
           int'(b & 8'hFF) & m, int'((b >> 8) & 8'hFF) & m,
           int'((b >> 16) & 8'hFF) & m, int'(b >> 24) & m,
           (i % 7) != 3, "R3 random");
    end

    junk_idle(4);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule